// File: doc/BRIEF.md
# Receive Character Queue with Request Threshold

This block sits on the receive side of an asynchronous serial channel, after the bit-level deserialiser. Each character arrives already assembled and checked, with a parity-error flag and a framing-error flag. The block stores the character and its flags in an eight-entry first-in first-out queue. A CPU or a DMA engine drains the queue one entry per read strobe. The oldest entry is always on the read port, and its flags come out with it.

Two request outputs tell software when to read: an interrupt and a DMA request. Each has its own enable. Both follow a fill threshold that a select bit sets to either one entry or four entries. A separate availability status bit always means "at least one entry present", whatever the threshold setting.

The receiver accepts characters only while its enable input is high. When auto-enable is selected, an active-low carrier-detect input also gates intake. That input is resynchronised before use. If a character arrives with the queue full and no read in the same cycle, the character is dropped and a sticky overrun flag is set. An error-reset strobe clears that flag.

Top module: `serial_rx_queue`

## Requirements
- R1: Entries leave in arrival order. `rd_data`, `rd_perr` and `rd_ferr` always show the oldest stored entry, and the queue holds up to 8 entries.
- R2: `char_avail` is 1 exactly when at least one entry is stored, for either value of `thr_sel`.
- R3: With `thr_sel`=0, the request condition is true when at least one entry is stored.
- R4: With `thr_sel`=1, the request condition is true only when 4 or more entries are stored.
- R5: `rx_int` is 1 only when `int_en`=1 and the request condition holds. `rx_dma_req` is 1 only when `dma_en`=1 and the request condition holds. The two enables act independently.
- R6: A character presented on `wr_vld` is stored only while `rx_en`=1. While `rx_en`=0 it is discarded.
- R7: With `auto_en`=1, intake is blocked while the synchronised `carrier_n` is 1 and allowed while it is 0. `carrier_n` passes through two flip-flops, so a write is first affected on the third clock edge after `carrier_n` changes. With `auto_en`=0, `carrier_n` has no effect.
- R8: If a write arrives with 8 entries stored and no read in the same cycle, the stored contents are kept, the new character is dropped and `overrun` becomes 1 and stays 1.
- R9: An `err_rst` strobe clears `overrun` on the next edge. A new overrun in the same cycle takes priority over the clear.
- R10: Each `rd_stb` removes one entry. A read of an empty queue is ignored. A read and a write in the same cycle on a full queue both take effect, and no overrun is flagged.
- R11: `char_avail`, `rx_int` and `rx_dma_req` reflect the new occupancy in the same cycle the clock edge changes it, with no added latency.
- R12: After reset the queue is empty, and `char_avail`, `rx_int`, `rx_dma_req` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rx_en | input | 1 | Receiver enable; the register file clears it on reset |
| auto_en | input | 1 | Let carrier detect gate intake |
| carrier_n | input | 1 | Active-low carrier detect, asynchronous |
| thr_sel | input | 1 | 0: threshold of one entry, 1: threshold of four entries |
| int_en | input | 1 | Receive interrupt enable |
| dma_en | input | 1 | DMA request enable |
| wr_vld | input | 1 | An assembled character is present this cycle |
| wr_data | input | 8 | Character value |
| wr_perr | input | 1 | Parity error for the character |
| wr_ferr | input | 1 | Framing error for the character |
| rd_stb | input | 1 | Remove the oldest entry |
| err_rst | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Oldest character |
| rd_perr | output | 1 | Parity flag of the oldest entry |
| rd_ferr | output | 1 | Framing flag of the oldest entry |
| char_avail | output | 1 | At least one entry stored |
| rx_int | output | 1 | Receive interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach from the ports is the full queue. A read and a write must land together there, and the result must be a successful write with no overrun, distinct from the plain dropped write just before it. The stimulus table fills the queue through both threshold settings and pushes past eight entries once without a read. It then issues the combined read and write, while a reference queue in the bench follows the data and flags. The carrier gating needs the synchroniser delay to settle, so the bench changes `carrier_n` and waits two idle cycles before it presents the write that is meant to pass.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [CHAR_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_sync2.sv
module rxq_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_async;
      s2_q <= s1_q;
    end
  end

  assign q_sync = s2_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  rxq_entry_t din,
  output rxq_entry_t dout,
  output logic [CW-1:0] count,
  output logic       drop
);
  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, empty, wr_ok, rd_ok;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign rd_ok = pop && !empty;
  assign wr_ok = push && (!full || pop);
  assign drop  = push && full && !pop;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (rd_ok) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (wr_ok && !rd_ok)      cnt_d = cnt_q + 1'b1;
    else if (rd_ok && !wr_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == CW'(DEPTH)));
  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (cnt_q == '0));
  // R10
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/rxq_req.sv
module rxq_req #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned THR_HI = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          thr_sel,
  input  logic          int_en,
  input  logic          dma_en,
  output logic          avail,
  output logic          rx_int,
  output logic          rx_dma_req
);
  logic at_thr;

  always_comb begin
    avail  = (count != '0);
    at_thr = thr_sel ? (count >= CW'(THR_HI)) : avail;
  end

  assign rx_int     = int_en && at_thr;
  assign rx_dma_req = dma_en && at_thr;

  // R2
  int_needs_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_int || rx_dma_req) |-> avail);
  // R4
  hi_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_sel && rx_int) |-> (count >= CW'(THR_HI)));
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned THR_HI = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              auto_en,
  input  logic              carrier_n,
  input  logic              thr_sel,
  input  logic              int_en,
  input  logic              dma_en,
  input  logic              wr_vld,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              wr_perr,
  input  logic              wr_ferr,
  input  logic              rd_stb,
  input  logic              err_rst,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              char_avail,
  output logic              rx_int,
  output logic              rx_dma_req,
  output logic              overrun
);
  logic          carrier_n_s, intake_ok, push, drop;
  logic          ovr_q, ovr_d;
  logic [CW-1:0] count;
  rxq_entry_t    din, dout;

  rxq_sync2 #(.RST_VAL(1'b1)) u_cd_sync (
    .clk(clk), .rst_n(rst_n), .d_async(carrier_n), .q_sync(carrier_n_s)
  );

  always_comb begin
    intake_ok = rx_en && !(auto_en && carrier_n_s);
    push      = wr_vld && intake_ok;
    din.perr  = wr_perr;
    din.ferr  = wr_ferr;
    din.data  = wr_data;
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(rd_stb),
    .din(din), .dout(dout), .count(count), .drop(drop)
  );

  rxq_req #(.DEPTH(DEPTH), .THR_HI(THR_HI)) u_req (
    .clk(clk), .rst_n(rst_n), .count(count), .thr_sel(thr_sel),
    .int_en(int_en), .dma_en(dma_en), .avail(char_avail),
    .rx_int(rx_int), .rx_dma_req(rx_dma_req)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (err_rst) ovr_d = 1'b0;
    if (drop)    ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign overrun = ovr_q;
  assign rd_data = dout.data;
  assign rd_perr = dout.perr;
  assign rd_ferr = dout.ferr;

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && intake_ok && !rd_stb && count == CW'(DEPTH)) |=> overrun);
  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_rst) |=> overrun);
  // R6
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !char_avail) |=> !char_avail);
endmodule

// File: tb/serial_rx_queue_tb_top.sv
`timescale 1ns/1ps
module serial_rx_queue_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_en, auto_en, carrier_n, thr_sel, int_en, dma_en;
  logic wr_vld, wr_perr, wr_ferr, rd_stb, err_rst;
  logic [7:0] wr_data, rd_data;
  logic rd_perr, rd_ferr, char_avail, rx_int, rx_dma_req, overrun;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [9:0] mq [$];

  always #5 clk = ~clk;

  serial_rx_queue dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .auto_en(auto_en),
    .carrier_n(carrier_n), .thr_sel(thr_sel), .int_en(int_en),
    .dma_en(dma_en), .wr_vld(wr_vld), .wr_data(wr_data),
    .wr_perr(wr_perr), .wr_ferr(wr_ferr), .rd_stb(rd_stb),
    .err_rst(err_rst), .rd_data(rd_data), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .char_avail(char_avail), .rx_int(rx_int),
    .rx_dma_req(rx_dma_req), .overrun(overrun)
  );

  // [7] write, [6] read, [5] thr_sel, [4:1] expected occupancy, [0] expected overrun
  localparam logic [7:0] VEC [14] = '{
    8'b1000_0010, 8'b1010_0100, 8'b1010_0110, 8'b1010_1000,
    8'b0110_0110, 8'b1110_0110, 8'b1000_1000, 8'b1000_1010,
    8'b1000_1100, 8'b1000_1110, 8'b1001_0000, 8'b1001_0001,
    8'b1101_0001, 8'b0110_1111
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [7:0] d,
                      input logic pe, input logic fe, input logic er);
    @(negedge clk);
    wr_vld = w; rd_stb = r; wr_data = d; wr_perr = pe; wr_ferr = fe; err_rst = er;
    @(posedge clk);
    #1;
    wr_vld = 1'b0; rd_stb = 1'b0; err_rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b1; auto_en = 1'b0; carrier_n = 1'b1;
    thr_sel = 1'b0; int_en = 1'b1; dma_en = 1'b1;
    wr_vld = 1'b0; wr_data = '0; wr_perr = 1'b0; wr_ferr = 1'b0;
    rd_stb = 1'b0; err_rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 avail", 16'(char_avail), 16'd0);
    chk("R12 int", 16'(rx_int), 16'd0);
    chk("R12 dma", 16'(rx_dma_req), 16'd0);
    chk("R12 overrun", 16'(overrun), 16'd0);

    for (int i = 0; i < 14; i++) begin
      logic w, r, t;
      logic [3:0] ec;
      logic [7:0] d;
      logic pe, fe, ereq;
      w = VEC[i][7]; r = VEC[i][6]; t = VEC[i][5]; ec = VEC[i][4:1];
      d = 8'h40 + 8'(i); pe = i[0]; fe = i[1];
      @(negedge clk);
      thr_sel = t;
      step(w, r, d, pe, fe, 1'b0);
      if (r && mq.size() > 0) void'(mq.pop_front());
      if (w && mq.size() < 8) mq.push_back({pe, fe, d});
      ereq = t ? (ec >= 4) : (ec != 0);
      // R11: outputs checked right after the edge that changed occupancy
      chk("R2 R11 avail", 16'(char_avail), 16'(ec != 0));
      chk(t ? "R4 R11 int" : "R3 R11 int", 16'(rx_int), 16'(ereq));
      chk("R5 dma", 16'(rx_dma_req), 16'(ereq));
      chk(i >= 11 ? "R8 R10 overrun" : "R8 overrun", 16'(overrun), 16'(VEC[i][0]));
      chk("R1 head", 16'({rd_perr, rd_ferr, rd_data}), 16'(mq[0]));
    end

    // R9 clear
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R9 cleared", 16'(overrun), 16'd0);
    chk("R9 avail kept", 16'(char_avail), 16'd1);

    // R1 drain in order, R10 one per strobe
    thr_sel = 1'b0;
    while (mq.size() > 0) begin
      chk("R1 order", 16'({rd_perr, rd_ferr, rd_data}), 16'(mq[0]));
      step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
      void'(mq.pop_front());
      chk("R10 avail", 16'(char_avail), 16'(mq.size() != 0));
    end
    step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R10 empty read", 16'(char_avail), 16'd0);
    chk("R10 empty read ovr", 16'(overrun), 16'd0);

    // R6 receiver disabled
    rx_en = 1'b0;
    step(1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0);
    chk("R6 blocked", 16'(char_avail), 16'd0);
    rx_en = 1'b1;

    // R7 carrier gating
    auto_en = 1'b1;
    step(1'b1, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0);
    chk("R7 no carrier", 16'(char_avail), 16'd0);
    @(negedge clk); carrier_n = 1'b0;
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 8'h33, 1'b1, 1'b0, 1'b0);
    chk("R7 carrier on", 16'(char_avail), 16'd1);
    chk("R7 data", 16'({rd_perr, rd_ferr, rd_data}), 16'({1'b1, 1'b0, 8'h33}));
    step(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    auto_en = 1'b0; carrier_n = 1'b1;
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 8'h44, 1'b0, 1'b1, 1'b0);
    chk("R7 auto off", 16'(char_avail), 16'd1);
    chk("R7 auto off data", 16'({rd_perr, rd_ferr, rd_data}), 16'({1'b0, 1'b1, 8'h44}));

    // R5 independent enables, one entry, thr_sel 0
    @(negedge clk); int_en = 1'b0; dma_en = 1'b1; #1;
    chk("R5 int off", 16'(rx_int), 16'd0);
    chk("R5 dma on", 16'(rx_dma_req), 16'd1);
    @(negedge clk); int_en = 1'b1; dma_en = 1'b0; #1;
    chk("R5 int on", 16'(rx_int), 16'd1);
    chk("R5 dma off", 16'(rx_dma_req), 16'd0);
    @(negedge clk); thr_sel = 1'b1; dma_en = 1'b1; #1;
    chk("R4 one entry", 16'(rx_int), 16'd0);
    chk("R2 thr independent", 16'(char_avail), 16'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule